// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the software-facing register file of one channel in a descriptor-driven DMA controller. A processor reaches it through a simple single-beat memory-mapped port. The port carries only full 32-bit words. The block holds the channel configuration, the three saved pointers, the interrupt raw, mask and masked values, the command word and the stream-command word. It drives one level-sensitive interrupt line.

Writes to the stream-command and command registers are turned into single-cycle action pulses for a separate transfer engine. These pulses are: fetch a data descriptor, fetch a context, start, and continue. The engine returns three things: interrupt-set strobes, its end-of-list flag and the end-of-list bit of its current data descriptor. The status word is not a stored register. It is assembled on each read from the channel state, the end-of-list flag and the source of the last stream command.

The register window is 0x2000 bytes, so the channel index is the bus offset shifted right by 13. This unit receives only the 13-bit offset inside its own window. All bus traffic is plain control access with no streaming path, so the port has no back-pressure. A read returns its data on the cycle after it is presented, and every access completes in one cycle.

Top module: `dmach_regs`

## Requirements
- R1: After reset, the status word reads 0x101 (state code 1, command source 1), every other register reads zero, and the interrupt line is low.
- R2: A configuration write (offset 0x00) with bit 1 set puts the state into stopped (code 2). A configuration write with bit 0 clear puts it into reset/idle (code 1); when both conditions hold, reset/idle wins. Any other configuration write leaves the state unchanged.
- R3: A stream-command write (offset 0x9C) uses only its bits 9:0. If any bit of 0x140 is set, a load-data pulse is issued. If, in addition, bit 0x20 is set, a start pulse is issued.
- R4: A stream command with bit 0x200 set issues a load-context pulse together with a start pulse. A start moves the state to running (code 4).
- R5: A write to the command register (offset 0x04) issues a continue pulse only when configuration bit 0 is set, configuration bit 1 is clear, the state is running and the engine reports that its current descriptor has end-of-list set.
- R6: A write to the acknowledge register (offset 0x90) clears the matching raw interrupt bits. The acknowledge register always reads back as zero.
- R7: The masked value (offset 0x98) equals raw (offset 0x94) AND mask (offset 0x8C), and follows mask or acknowledge writes on the next cycle. The interrupt line is high exactly when the masked value is nonzero.
- R8: Engine set strobes OR into the raw bits. A set arriving in the same cycle as an acknowledge of the same bit leaves that bit set.
- R9: The status word (offset 0x08) carries the state in bits 2:0, the engine end-of-list flag in bit 5 and the command source in bits 9:8. The command source becomes 2 after any stream-command write.
- R10: A byte or halfword access (size not 2) raises the error output on the next cycle. It changes no register and issues no pulse; a read of this kind returns zero.
- R11: The saved data pointer (0x58), saved buffer pointer (0x5C) and group-down pointer (0x7C) store full words and read back on the cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access presented this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 13 | Byte offset inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| bus_err | output | 1 | Sub-word access flag, one cycle after the access |
| eng_intr_set | input | 4 | Raw interrupt set strobes from the engine |
| eng_list_end | input | 1 | Engine end-of-list flag |
| eng_desc_last | input | 1 | Current data descriptor has end-of-list set |
| irq | output | 1 | Level interrupt |
| load_data_o | output | 1 | Fetch data descriptor pulse |
| load_ctx_o | output | 1 | Fetch context pulse |
| start_o | output | 1 | Start channel pulse |
| continue_o | output | 1 | Continue pulse |

## Verification
On every cycle, the assertions check the following. The state code is one-hot. A start pulse always coincides with the running state, and a load-context pulse always comes with a start. A continue pulse only appears while the channel is enabled, not stopped and running. Acknowledged bits are gone and set strobes have landed one cycle later. A sub-word access changes no stored word. Only the bench scenarios show the decoded values themselves. These are the exact stream-command patterns that produce each pulse, the precedence of reset over stop in a configuration write, the assembled status word, and the read-back of mask, raw, masked and acknowledge values at their offsets.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int DW = 32;
  localparam int AW = 13;
  localparam int IW = 4;
  localparam int CW = 10;

  localparam logic [2:0] ST_IDLE = 3'd1;
  localparam logic [2:0] ST_STOP = 3'd2;
  localparam logic [2:0] ST_RUN  = 3'd4;

  localparam logic [AW-1:0] OFF_CFG    = 13'h000;
  localparam logic [AW-1:0] OFF_CMD    = 13'h004;
  localparam logic [AW-1:0] OFF_STAT   = 13'h008;
  localparam logic [AW-1:0] OFF_SDATA  = 13'h058;
  localparam logic [AW-1:0] OFF_SBUF   = 13'h05C;
  localparam logic [AW-1:0] OFF_GDOWN  = 13'h07C;
  localparam logic [AW-1:0] OFF_MASK   = 13'h08C;
  localparam logic [AW-1:0] OFF_ACK    = 13'h090;
  localparam logic [AW-1:0] OFF_RAW    = 13'h094;
  localparam logic [AW-1:0] OFF_MASKED = 13'h098;
  localparam logic [AW-1:0] OFF_SCMD   = 13'h09C;

  localparam logic [CW-1:0] SC_LOAD_D = 10'h140;
  localparam logic [CW-1:0] SC_BURST  = 10'h020;
  localparam logic [CW-1:0] SC_LOAD_C = 10'h200;
endpackage

// File: rtl/dmach_irq.sv
module dmach_irq
  import dmach_pkg::*;
#(
  parameter int W = IW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         ack_we,
  input  logic [W-1:0] ack_wdata,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, mask_q, masked_q;
  logic [W-1:0] raw_d, mask_d, clr;

  always_comb begin
    clr    = ack_we ? ack_wdata : '0;
    raw_d  = (raw_q & ~clr) | set_i;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= '0;
      mask_q   <= '0;
      masked_q <= '0;
    end else begin
      raw_q    <= raw_d;
      mask_q   <= mask_d;
      masked_q <= raw_d & mask_d;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = masked_q;
  assign irq_o    = |masked_q;

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ((ack_wdata & set_i) == '0)) |=> ((raw_q & $past(ack_wdata)) == '0));
  // R8
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)));
  // R7
  masked_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_q & ~raw_q) == '0));
endmodule

// File: rtl/dmach_cmd.sv
module dmach_cmd
  import dmach_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_wdata,
  input  logic          cmd_we,
  input  logic          scmd_we,
  input  logic [CW-1:0] scmd_wdata,
  input  logic          desc_last,
  output logic [1:0]    cfg_o,
  output logic [2:0]    state_o,
  output logic [1:0]    src_o,
  output logic          load_d_o,
  output logic          load_c_o,
  output logic          start_o,
  output logic          cont_o
);
  logic [1:0] cfg_q, src_q;
  logic [2:0] state_q;
  logic       ld_q, lc_q, st_q, ct_q;
  logic       want_ld, want_lc, want_st, may_cont;

  always_comb begin
    want_ld  = scmd_we && ((scmd_wdata & SC_LOAD_D) != '0);
    want_lc  = scmd_we && ((scmd_wdata & SC_LOAD_C) != '0);
    want_st  = (want_ld && ((scmd_wdata & SC_BURST) != '0)) || want_lc;
    may_cont = cmd_we && cfg_q[0] && !cfg_q[1] && (state_q == ST_RUN) && desc_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      src_q   <= 2'd1;
      state_q <= ST_IDLE;
      ld_q    <= 1'b0;
      lc_q    <= 1'b0;
      st_q    <= 1'b0;
      ct_q    <= 1'b0;
    end else begin
      ld_q <= want_ld;
      lc_q <= want_lc;
      st_q <= want_st;
      ct_q <= may_cont;
      if (scmd_we) src_q <= 2'd2;
      if (cfg_we) begin
        cfg_q <= cfg_wdata;
        if (!cfg_wdata[0])     state_q <= ST_IDLE;
        else if (cfg_wdata[1]) state_q <= ST_STOP;
      end else if (want_st) begin
        state_q <= ST_RUN;
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign state_o  = state_q;
  assign src_o    = src_q;
  assign load_d_o = ld_q;
  assign load_c_o = lc_q;
  assign start_o  = st_q;
  assign cont_o   = ct_q;

  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_q));
  // R4
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |-> (state_q == ST_RUN));
  // R4
  ctx_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_q |-> st_q);
  // R5
  cont_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ct_q |-> (cfg_q == 2'b01 && state_q == ST_RUN));
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  input  logic [IW-1:0] eng_intr_set,
  input  logic          eng_list_end,
  input  logic          eng_desc_last,
  output logic          irq,
  output logic          load_data_o,
  output logic          load_ctx_o,
  output logic          start_o,
  output logic          continue_o
);
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic          ok, wr, rd;
  logic [DW-1:0] sdata_q, sbuf_q, gdown_q, cmd_q, scmd_q, rdata_q, rmux;
  logic          err_q;
  logic [IW-1:0] raw, mask, masked;
  logic [1:0]    cfg, src;
  logic [2:0]    state;

  assign ok = (bus_size == SZ_WORD);
  assign wr = bus_en && bus_we && ok;
  assign rd = bus_en && !bus_we && ok;

  dmach_irq #(.W(IW)) u_irq (
    .clk, .rst_n,
    .mask_we   (wr && bus_addr == OFF_MASK),
    .mask_wdata(bus_wdata[IW-1:0]),
    .ack_we    (wr && bus_addr == OFF_ACK),
    .ack_wdata (bus_wdata[IW-1:0]),
    .set_i     (eng_intr_set),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq)
  );

  dmach_cmd u_cmd (
    .clk, .rst_n,
    .cfg_we    (wr && bus_addr == OFF_CFG),
    .cfg_wdata (bus_wdata[1:0]),
    .cmd_we    (wr && bus_addr == OFF_CMD),
    .scmd_we   (wr && bus_addr == OFF_SCMD),
    .scmd_wdata(bus_wdata[CW-1:0]),
    .desc_last (eng_desc_last),
    .cfg_o     (cfg),
    .state_o   (state),
    .src_o     (src),
    .load_d_o  (load_data_o),
    .load_c_o  (load_ctx_o),
    .start_o   (start_o),
    .cont_o    (continue_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= '0;
      sbuf_q  <= '0;
      gdown_q <= '0;
      cmd_q   <= '0;
      scmd_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFF_SDATA: sdata_q <= bus_wdata;
        OFF_SBUF:  sbuf_q  <= bus_wdata;
        OFF_GDOWN: gdown_q <= bus_wdata;
        OFF_CMD:   cmd_q   <= bus_wdata;
        OFF_SCMD:  scmd_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      OFF_CFG:    rmux[1:0] = cfg;
      OFF_CMD:    rmux = cmd_q;
      OFF_STAT: begin
        rmux[2:0] = state;
        rmux[5]   = eng_list_end;
        rmux[9:8] = src;
      end
      OFF_SDATA:  rmux = sdata_q;
      OFF_SBUF:   rmux = sbuf_q;
      OFF_GDOWN:  rmux = gdown_q;
      OFF_MASK:   rmux[IW-1:0] = mask;
      OFF_RAW:    rmux[IW-1:0] = raw;
      OFF_MASKED: rmux[IW-1:0] = masked;
      OFF_SCMD:   rmux = scmd_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= bus_en && !ok;
      rdata_q <= rd ? rmux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R10
  bad_size_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !ok) |=> ($stable(sdata_q) && $stable(sbuf_q) && $stable(gdown_q)
                         && $stable(scmd_q) && $stable(mask) && $stable(cfg)));
  // R10
  bad_size_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !ok) |=> (!load_data_o && !load_ctx_o && !start_o && !continue_o));
endmodule

// File: tb/sim_dmach_regs.sv
module sim_dmach_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_en = 0, bus_we = 0;
  logic [1:0]  bus_size = 2;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, irq, load_data_o, load_ctx_o, start_o, continue_o;
  logic [3:0]  eng_intr_set = '0;
  logic        eng_list_end = 0, eng_desc_last = 0;

  int checks = 0, failures = 0;
  logic [3:0] pulses;
  logic       err_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmach_regs u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pulses = {load_data, load_ctx, start, continue}, captured after the write edge
  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [1:0] sz = 2);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk); #1;
    pulses   = {load_data_o, load_ctx_o, start_o, continue_o};
    err_seen = bus_err;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_size = 2;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d, input logic [1:0] sz = 2);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    @(posedge clk); #1;
    d = bus_rdata;
    err_seen = bus_err;
    @(negedge clk);
    bus_en = 0; bus_size = 2;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(13'h008, v); chk("R1 status", v, 32'h101);
    rd(13'h08C, v); chk("R1 mask", v, 0);
    rd(13'h058, v); chk("R1 saved data", v, 0);
    rd(13'h000, v); chk("R1 cfg", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_pointers;
    logic [31:0] v;
    wr(13'h058, 32'hDEAD_0040);
    wr(13'h05C, 32'h1234_5678);
    wr(13'h07C, 32'h8000_0F00);
    rd(13'h058, v); chk("R11 saved data", v, 32'hDEAD_0040);
    rd(13'h05C, v); chk("R11 saved buf", v, 32'h1234_5678);
    rd(13'h07C, v); chk("R11 group down", v, 32'h8000_0F00);
  endtask

  task automatic t_stream;
    logic [31:0] v;
    wr(13'h000, 1);
    rd(13'h008, v); chk("R2 enable keeps state", v[2:0], 1);
    wr(13'h09C, 32'h040); chk("R3 load only", pulses, 4'b1000);
    rd(13'h008, v); chk("R9 status after cmd", v, 32'h201);
    wr(13'h09C, 32'h420); chk("R3 high bits ignored", pulses, 4'b0000);
    wr(13'h09C, 32'h160); chk("R3 load+start", pulses, 4'b1010);
    rd(13'h008, v); chk("R4 running", v[2:0], 4);
    wr(13'h09C, 32'h200); chk("R4 ctx+start", pulses, 4'b0110);
    wr(13'h09C, 32'h240); chk("R4 both loads", pulses, 4'b1110);
    eng_list_end = 1;
    rd(13'h008, v); chk("R9 eol bit", v, 32'h224);
    eng_list_end = 0;
  endtask

  task automatic t_continue;
    logic [31:0] v;
    eng_desc_last = 1;
    wr(13'h004, 32'h1); chk("R5 continue ok", pulses, 4'b0001);
    eng_desc_last = 0;
    wr(13'h004, 32'h1); chk("R5 no eol", pulses, 4'b0000);
    eng_desc_last = 1;
    wr(13'h000, 3);
    rd(13'h008, v); chk("R2 stop", v[2:0], 2);
    wr(13'h004, 32'h1); chk("R5 stopped", pulses, 4'b0000);
    wr(13'h000, 1);
    wr(13'h004, 32'h1); chk("R5 not running", pulses, 4'b0000);
    wr(13'h09C, 32'h200);
    wr(13'h000, 0);
    rd(13'h008, v); chk("R2 reset", v[2:0], 1);
    wr(13'h000, 1); wr(13'h09C, 32'h200);
    wr(13'h000, 2);
    rd(13'h008, v); chk("R2 reset beats stop", v[2:0], 1);
    eng_desc_last = 0;
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk); eng_intr_set = 4'b0101;
    @(negedge clk); eng_intr_set = 0;
    rd(13'h094, v); chk("R8 raw set", v, 5);
    chk("R7 masked off", irq, 0);
    wr(13'h08C, 4);
    chk("R7 irq high", irq, 1);
    rd(13'h098, v); chk("R7 masked", v, 4);
    wr(13'h090, 4);
    chk("R7 irq low", irq, 0);
    rd(13'h094, v); chk("R6 cleared", v, 1);
    rd(13'h090, v); chk("R6 ack zero", v, 0);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 13'h090; bus_wdata = 1; eng_intr_set = 4'b0001;
    @(negedge clk);
    bus_en = 0; bus_we = 0; eng_intr_set = 0;
    rd(13'h094, v); chk("R8 set beats ack", v, 1);
  endtask

  task automatic t_err;
    logic [31:0] v;
    wr(13'h08C, 32'hF, 1); chk("R10 err half", err_seen, 1);
    rd(13'h08C, v); chk("R10 mask kept", v, 4);
    wr(13'h09C, 32'h260, 0); chk("R10 no pulses", pulses, 0);
    chk("R10 err byte", err_seen, 1);
    rd(13'h058, v, 1); chk("R10 read zero", v, 0);
    chk("R10 read err", err_seen, 1);
    rd(13'h058, v); chk("R10 word ok", err_seen, 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD*3) rst_n = 1;
        t_reset; t_pointers; t_stream; t_continue; t_irq; t_err;
      end
      begin
        #(CLK_PERIOD*100000);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule